// File: doc/BRIEF.md
# Pin-Change Interrupt GPIO Port

An eight-pin general-purpose I/O port that a processor manages through a small register file on a simple synchronous bus. Each pin can act as a plain input or output, or it can be handed to a peripheral. The port has no arbitration of its own: the register bits only steer the pin's data and enable between the port's own output value and the peripheral's drive. It also reports the pull-resistor setting per pin, so that the pad can apply a weak pull-up or pull-down.

Every pin is synchronized through two flops. A pin can latch an interrupt flag on a chosen edge, either rising or falling. An interrupt request is raised while any flagged pin is also enabled. A read-only vector register gives a priority code for the lowest-numbered pending pin. Reading the vector register acknowledges that one pin, so a handler can use the code directly as a jump-table offset.

Top module: `gpio_edge_port`

## Requirements
- R1: Register offsets on busAddr are as follows. 0 is the synchronized input and is read-only. 1 is output, 2 is direction, 3 is function select, 4 is pull enable, 5 is edge select, 6 is interrupt enable, 7 is the interrupt flags, and 8 is the vector, which is read-only. Each writable register reads back the value written to it. Writes to offsets 0 and 8 are ignored, and any other offset reads 0. Read data is valid while busRe is high in the same cycle, and a write takes effect on the clock edge where busWe is high.
- R2: Out of reset every register is 0, so pinOe is 0, irq is 0 and periphIn is 0.
- R3: The input register shows pinIn after two clock edges of synchronization. This holds for every pin, including pins given to the peripheral.
- R4: When a pin's select bit is 0, pinOut carries its output bit and pinOe carries its direction bit (1 = drive). When the select bit is 1, pinOut and pinOe pass through periphOut and periphOe.
- R5: pullEn equals the pull-enable register. pullUp is 1 only where pull is enabled and the output bit is 1; output bit 0 means pull-down.
- R6: A flag is set on the edge after (edge-select XOR synchronized input) goes from 0 to 1. An edge-select bit of 0 therefore catches a rising pin and 1 catches a falling pin, and a pin change shows in the flag after three clock edges.
- R7: Writing the flag register sets and clears flags to the written value. A hardware set in the same cycle as a write of 0 wins.
- R8: irq is 1 exactly while some pin has both its flag and its enable set.
- R9: The vector reads 2n+2 for the lowest pin n that is both flagged and enabled, and 0 when no pin is. A read clears only flag n.
- R10: A pin whose select bit is 1 never has its flag set by a pin transition.
- R11: periphIn follows the synchronized pin while the select bit is 1, and holds its last value while the select bit is 0.
- R12: A pin configured as a general-purpose output still sets its flag on the selected edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register offset |
| busWdata | input | 16 | Write data |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (acknowledges the vector) |
| busRdata | output | 16 | Read data for busAddr |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Pin output value |
| pinOe | output | 8 | Pin output enable |
| pullEn | output | 8 | Weak pull enable per pin |
| pullUp | output | 8 | Pull direction per pin, 1 = up |
| periphOut | input | 8 | Peripheral drive value |
| periphOe | input | 8 | Peripheral output enable |
| periphIn | output | 8 | Pin value delivered to the peripheral |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a hardware flag set landing on the same clock edge as a software write that clears the flags. Here the pin input has to be timed against the synchronizer latency. The stimulus changes a pin on a falling edge and then lets exactly two rising edges pass. The flag-clear write is then issued so that it commits on the third edge, which is the one where the edge detector fires. The flag must survive that write. Vector acknowledgment with masked and unmasked flags is reached by setting flags directly through the flag register.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_IN   = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_OUT  = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_SEL  = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_PULL = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_EDGE = 4'd5;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_FLAG = 4'd7;
  localparam logic [ADDR_W-1:0] OFF_VEC  = 4'd8;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrSel;
    logic wrPull;
    logic wrEdge;
    logic wrIen;
    logic wrFlag;
    logic rdVec;
    logic [ADDR_W-1:0] rdSel;
  } busStrobeT;
endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output busStrobeT         stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = busAddr;
    stb.rdVec = busRe && (busAddr == OFF_VEC);
    if (busWe) begin
      case (busAddr)
        OFF_OUT:  stb.wrOut  = 1'b1;
        OFF_DIR:  stb.wrDir  = 1'b1;
        OFF_SEL:  stb.wrSel  = 1'b1;
        OFF_PULL: stb.wrPull = 1'b1;
        OFF_EDGE: stb.wrEdge = 1'b1;
        OFF_IEN:  stb.wrIen  = 1'b1;
        OFF_FLAG: stb.wrFlag = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int PINS  = 8,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobeT        stb,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic [PINS-1:0]  pinIn,
  output logic [PINS-1:0]  pinOut,
  output logic [PINS-1:0]  pinOe,
  output logic [PINS-1:0]  pullEn,
  output logic [PINS-1:0]  pullUp,
  input  logic [PINS-1:0]  periphOut,
  input  logic [PINS-1:0]  periphOe,
  output logic [PINS-1:0]  periphIn,
  output logic             irq
);
  localparam int VEC_MAX = 2 * PINS + 2;

  logic [PINS-1:0] wrVal;
  logic [PINS-1:0] syncA, syncB;
  logic [PINS-1:0] outReg, dirReg, selReg, pullReg, edgeReg, ienReg, flagReg;
  logic [PINS-1:0] prevTrig, trigNow, riseVec, flagNext, pend, lowMask;
  logic [PINS-1:0] periphHold;
  logic [BUS_W-1:0] vecCode;

  assign wrVal = busWdata[PINS-1:0];

  generate
    if (BUS_W > PINS) begin : g_unused
      logic unusedHigh;
      assign unusedHigh = ^busWdata[BUS_W-1:PINS];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevTrig <= '0;
      outReg <= '0; dirReg <= '0; selReg <= '0; pullReg <= '0;
      edgeReg <= '0; ienReg <= '0; flagReg <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      prevTrig <= trigNow;
      flagReg  <= flagNext;
      if (stb.wrOut)  outReg  <= wrVal;
      if (stb.wrDir)  dirReg  <= wrVal;
      if (stb.wrSel)  selReg  <= wrVal;
      if (stb.wrPull) pullReg <= wrVal;
      if (stb.wrEdge) edgeReg <= wrVal;
      if (stb.wrIen)  ienReg  <= wrVal;
    end
  end

  assign trigNow = edgeReg ^ syncB;
  assign riseVec = trigNow & ~prevTrig & ~selReg;
  assign pend    = flagReg & ienReg;
  assign lowMask = pend & (~pend + 1'b1);
  assign irq     = |pend;

  always_comb begin
    flagNext = flagReg;
    if (stb.wrFlag)     flagNext = wrVal;
    else if (stb.rdVec) flagNext = flagReg & ~lowMask;
    flagNext = flagNext | riseVec;
  end

  always_comb begin
    vecCode = '0;
    for (int i = PINS - 1; i >= 0; i--)
      if (pend[i]) vecCode = BUS_W'(2 * i + 2);
  end

  always_comb begin
    case (stb.rdSel)
      OFF_IN:   busRdata = BUS_W'(syncB);
      OFF_OUT:  busRdata = BUS_W'(outReg);
      OFF_DIR:  busRdata = BUS_W'(dirReg);
      OFF_SEL:  busRdata = BUS_W'(selReg);
      OFF_PULL: busRdata = BUS_W'(pullReg);
      OFF_EDGE: busRdata = BUS_W'(edgeReg);
      OFF_IEN:  busRdata = BUS_W'(ienReg);
      OFF_FLAG: busRdata = BUS_W'(flagReg);
      OFF_VEC:  busRdata = vecCode;
      default:  busRdata = '0;
    endcase
  end

  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      assign pinOut[p] = selReg[p] ? periphOut[p] : outReg[p];
      assign pinOe[p]  = selReg[p] ? periphOe[p]  : dirReg[p];
      assign pullEn[p] = pullReg[p];
      assign pullUp[p] = pullReg[p] & outReg[p];
      always_ff @(posedge clk) begin
        if (!rstN)          periphHold[p] <= 1'b0;
        else if (selReg[p]) periphHold[p] <= syncB[p];
      end
      assign periphIn[p] = periphHold[p];
    end
  endgenerate

  // R6 and R7: a detected edge always lands in the flag, even across a write
  assert_edge_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec != '0) |=> ((flagReg & $past(riseVec)) == $past(riseVec)));

  // R7: a software write stores the written bits apart from concurrent edges
  assert_write_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrFlag |=> ((flagReg & ~$past(riseVec)) == ($past(wrVal) & ~$past(riseVec))));

  // R8: the request and the vector agree
  assert_irq_has_vector_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (vecCode != '0));

  // R9: the vector code is even and in range
  assert_vector_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (vecCode[0] == 1'b0) && (vecCode <= BUS_W'(VEC_MAX - 2)));

  // R9: an acknowledge with no edge retires exactly one flag
  assert_ack_clears_one_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdVec && (pend != '0) && (riseVec == '0)) |=>
      ($countones(flagReg) == $countones($past(flagReg)) - 1));

  // R10: pins on the peripheral path never gain a flag from hardware
  assert_sel_blocks_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.wrFlag) |-> ((flagReg & ~$past(flagReg) & $past(selReg)) == '0));

  // R11: the peripheral view is frozen on general-purpose pins
  assert_periph_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((periphIn ^ $past(periphIn)) & ~$past(selReg)) == '0));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int PINS  = 8,
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic [PINS-1:0]   pullEn,
  output logic [PINS-1:0]   pullUp,
  input  logic [PINS-1:0]   periphOut,
  input  logic [PINS-1:0]   periphOe,
  output logic [PINS-1:0]   periphIn,
  output logic              irq
);
  busStrobeT stb;

  gpio_edge_ctrl u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .stb(stb)
  );

  gpio_edge_dp #(.PINS(PINS), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pullEn(pullEn), .pullUp(pullUp),
    .periphOut(periphOut), .periphOe(periphOe), .periphIn(periphIn), .irq(irq)
  );
endmodule

// File: tb/sim_gpio_edge_port.sv
module sim_gpio_edge_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [15:0] busRdata;
  logic [7:0] pinIn = '0, periphOut = '0, periphOe = '0;
  logic [7:0] pinOut, pinOe, pullEn, pullUp, periphIn;
  logic irq;

  int nVec = 0, nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio_edge_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRe(busRe), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pullEn(pullEn), .pullUp(pullUp), .periphOut(periphOut), .periphOe(periphOe),
    .periphIn(periphIn), .irq(irq)
  );

  // address, write data, expected read-back
  localparam logic [35:0] TBL [8] = '{
    {4'h1, 16'h00A5, 16'h00A5},
    {4'h2, 16'h003C, 16'h003C},
    {4'h4, 16'h0081, 16'h0081},
    {4'h6, 16'h00C3, 16'h00C3},
    {4'h7, 16'h0055, 16'h0055},
    {4'h0, 16'h00FF, 16'h0000},
    {4'hE, 16'h1234, 16'h0000},
    {4'h5, 16'h0000, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nVec++; nBad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 pinOe in reset", {8'h0, pinOe}, 16'h0);
    check("R2 irq in reset", {15'h0, irq}, 16'h0);
    rstN = 1'b1;
    rd(4'h7, r); check("R2 flags after reset", r, 16'h0);
    rd(4'h3, r); check("R2 select after reset", r, 16'h0);
    rd(4'h8, r); check("R2 vector after reset", r, 16'h0);
    check("R2 periphIn after reset", {8'h0, periphIn}, 16'h0);

    for (int i = 0; i < 8; i++) begin
      wr(TBL[i][35:32], TBL[i][31:16]);
      rd(TBL[i][35:32], r);
      check("R1 register table", r, TBL[i][15:0]);
    end
    wr(4'h6, 0); wr(4'h7, 0); wr(4'h2, 0); wr(4'h4, 0); wr(4'h1, 0);

    // R3 input synchronization: visible after two edges
    @(negedge clk); pinIn = 8'h3C;
    repeat (2) @(posedge clk);
    rd(4'h0, r); check("R3 input after two edges", r, 16'h003C);
    @(negedge clk); pinIn = 8'h00; settle(); wr(4'h7, 0);

    // R4 output mux
    wr(4'h1, 16'h00A5); wr(4'h2, 16'h00F0);
    @(negedge clk);
    check("R4 pinOut gpio", {8'h0, pinOut}, 16'h00A5);
    check("R4 pinOe gpio", {8'h0, pinOe}, 16'h00F0);
    periphOut = 8'h5A; periphOe = 8'h03;
    wr(4'h3, 16'h000F);
    @(negedge clk);
    check("R4 pinOut mixed", {8'h0, pinOut}, 16'h00AA);
    check("R4 pinOe mixed", {8'h0, pinOe}, 16'h00F3);
    wr(4'h3, 0);

    // R5 pulls
    wr(4'h4, 16'h0033);
    @(negedge clk);
    check("R5 pullEn", {8'h0, pullEn}, 16'h0033);
    check("R5 pullUp", {8'h0, pullUp}, 16'h0021);
    wr(4'h4, 0); wr(4'h1, 0); wr(4'h2, 0);

    // R6 rising edge, latency three edges
    @(negedge clk); pinIn = 8'h01;
    repeat (2) @(posedge clk);
    @(negedge clk); busAddr = 4'h7; #1;
    check("R6 no flag before third edge", busRdata, 16'h0);
    @(posedge clk); @(negedge clk); #1;
    check("R6 flag on third edge", busRdata, 16'h0001);
    // R6 falling edge with edge select 1
    pinIn = 8'h03; settle();
    wr(4'h5, 16'h0002); wr(4'h7, 0);
    rd(4'h7, r); check("R6 no flag on select change", r, 16'h0);
    @(negedge clk); pinIn = 8'h01; settle();
    rd(4'h7, r); check("R6 falling edge flag", r, 16'h0002);
    wr(4'h7, 0);
    @(negedge clk); pinIn = 8'h03; settle();
    rd(4'h7, r); check("R6 rising ignored when select 1", r, 16'h0);
    wr(4'h5, 0); wr(4'h7, 0);
    @(negedge clk); pinIn = 8'h00; settle(); wr(4'h7, 0);

    // R8 request
    wr(4'h7, 16'h0004);
    @(negedge clk); check("R8 irq low when disabled", {15'h0, irq}, 16'h0);
    wr(4'h6, 16'h0004);
    @(negedge clk); check("R8 irq high when enabled", {15'h0, irq}, 16'h1);
    wr(4'h7, 0);
    @(negedge clk); check("R8 irq drops with flag", {15'h0, irq}, 16'h0);

    // R9 vector
    wr(4'h6, 16'h00FF); wr(4'h7, 16'h0028);
    rd(4'h8, r); check("R9 vector lowest pin 3", r, 16'h0008);
    rd(4'h7, r); check("R9 read clears only pin 3", r, 16'h0020);
    rd(4'h8, r); check("R9 vector pin 5", r, 16'h000C);
    rd(4'h7, r); check("R9 flags empty", r, 16'h0);
    rd(4'h8, r); check("R9 vector none", r, 16'h0);
    wr(4'h7, 16'h0028); wr(4'h6, 16'h0020);
    rd(4'h8, r); check("R9 masked pin skipped", r, 16'h000C);
    rd(4'h7, r); check("R9 masked flag kept", r, 16'h0008);
    wr(4'h6, 0); wr(4'h7, 0);

    // R7 hardware set beats a simultaneous clear
    @(negedge clk); pinIn = 8'h40;
    repeat (2) @(posedge clk);
    wr(4'h7, 16'h0000);
    rd(4'h7, r); check("R7 hardware set wins", r, 16'h0040);
    wr(4'h7, 16'h0081);
    rd(4'h7, r); check("R7 software set", r, 16'h0081);
    wr(4'h7, 0);
    @(negedge clk); pinIn = 8'h00; settle(); wr(4'h7, 0);

    // R10 and R11 peripheral pin
    wr(4'h3, 16'h0010);
    @(negedge clk); pinIn = 8'h10; settle();
    rd(4'h7, r); check("R10 no flag on select pin", r, 16'h0);
    rd(4'h0, r); check("R3 input readable on select pin", r, 16'h0010);
    check("R11 periphIn follows", {8'h0, periphIn}, 16'h0010);
    wr(4'h3, 0); wr(4'h7, 0);
    @(negedge clk); pinIn = 8'h00; settle();
    check("R11 periphIn frozen", {8'h0, periphIn}, 16'h0010);
    wr(4'h7, 0);

    // R12 output pin still interrupts
    wr(4'h2, 16'h0001); wr(4'h6, 16'h0001);
    @(negedge clk); pinIn = 8'h01; settle();
    rd(4'h7, r); check("R12 output pin flag", r, 16'h0001);
    check("R12 output pin irq", {15'h0, irq}, 16'h1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule